// File: doc/BRIEF.md
# Compact 16-bit Varint Codec

This block turns 16-bit unsigned numbers into a short byte sequence and back. Each output byte carries seven value bits, least significant group first, plus a flag in bit 7 that says another byte follows. The length is capped at three bytes: the third byte holds only the two top value bits and never has a flag. Small numbers (below 128) therefore take a single byte, which suits length fields that are usually short.

The encoder takes one value at a time through a valid/ready handshake. It then drives the bytes one per transfer on a byte stream with valid, ready and a last marker. The decoder is a separate path. It accepts such a byte stream and presents the rebuilt value together with an error flag. Both paths stall cleanly under backpressure. The group width and value width are parameters, and the byte count and final-group width are derived from them.

Top module: `vlq_codec`

## Requirements
- R1: The first encoded byte carries value bits [6:0] in bits [6:0]. Its bit 7 is 1 exactly when the value is above 0x7F. A value below 128 is sent as one byte with last set.
- R2: For a value above 0x7F, the second byte carries value bits [13:7] in bits [6:0]. Its bit 7 is 1 exactly when the value is above 0x3FFF.
- R3: For a value above 0x3FFF, a third byte follows with value bits [15:14] in bits [1:0] and bits [7:2] zero. No value produces more than three bytes. Examples: 0x4000 gives 80 80 01, 0xC000 gives 80 80 03, 0xFFFF gives FF FF 03.
- R4: The encoder asserts last on the final byte of each value and on no other byte.
- R5: Once a value is accepted, the encoder input ready stays low until the final byte of that value has been accepted. It is high again in the next cycle.
- R6: While an encoder byte is valid and not accepted, its data and last stay unchanged.
- R7: The decoder rebuilds the value from a sequence of 1 to 3 bytes. The sequence ends at a byte with bit 7 clear or at the third byte. The value is reported with the error flag clear.
- R8: The decoder raises the error flag on a third byte that has any of bits [7:2] set.
- R9: After presenting a value, with or without error, the decoder treats the next byte as the first byte of a new value.
- R10: While the decoder output is valid and not accepted, the output value and error flag hold steady and the decoder input ready stays low.
- R11: After reset, both output valids are low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_in_valid | input | 1 | Encoder value offered |
| enc_in_ready | output | 1 | Encoder can take a value |
| enc_in_value | input | 16 | Value to encode |
| enc_byte_valid | output | 1 | Encoded byte offered |
| enc_byte_ready | input | 1 | Downstream takes the byte |
| enc_byte_data | output | 8 | Encoded byte |
| enc_byte_last | output | 1 | Final byte of the value |
| dec_byte_valid | input | 1 | Byte offered to decoder |
| dec_byte_ready | output | 1 | Decoder can take a byte |
| dec_byte_data | input | 8 | Byte to decode |
| dec_out_valid | output | 1 | Decoded value offered |
| dec_out_ready | input | 1 | Downstream takes the value |
| dec_out_value | output | 16 | Decoded value |
| dec_out_err | output | 1 | Malformed final byte seen |

## Verification
The first encoded byte is visible one cycle after the value transfer. Each later byte is visible one cycle after the previous byte transfer. Encoder input ready comes back one cycle after the last byte transfer. A decoded value appears one cycle after the byte that ends the sequence. The bench drives and samples on the falling clock edge, so each check reads the state that the preceding rising edge produced. Checks for stalls are repeated on every held cycle, not only at the end.

// File: rtl/vlq_pkg.sv
package vlq_pkg;
   // Number of encoded bytes needed for a value of val_w bits in grp_w-bit groups
   function automatic int unsigned grp_count(int unsigned val_w, int unsigned grp_w);
      return (val_w + grp_w - 1) / grp_w;
   endfunction
endpackage

// File: rtl/vlq_enc.sv
module vlq_enc #(
   parameter int unsigned VAL_W = 16,
   parameter int unsigned GRP_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [VAL_W-1:0]   in_value,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [GRP_W:0]     out_data,
   output logic               out_last
);
   import vlq_pkg::*;
   localparam int unsigned NBYTES = grp_count(VAL_W, GRP_W);
   localparam int unsigned IDX_W  = $clog2(NBYTES);

   if (GRP_W < 1 || VAL_W <= GRP_W) begin : g_bad_cfg
      $error("vlq_enc: VAL_W must exceed GRP_W >= 1");
   end

   logic [VAL_W-1:0] rem_q;
   logic [IDX_W-1:0] idx_q;
   logic             busy_q;
   logic             more;

   assign more      = (idx_q != IDX_W'(NBYTES - 1)) && ((rem_q >> GRP_W) != '0);
   assign out_valid = busy_q;
   assign out_data  = {more, rem_q[GRP_W-1:0]};
   assign out_last  = ~more;
   assign in_ready  = ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (!busy_q) begin
         if (in_valid) begin
            rem_q  <= in_value;
            idx_q  <= '0;
            busy_q <= 1'b1;
         end
      end else if (out_ready) begin
         if (!more) begin
            busy_q <= 1'b0;
         end else begin
            rem_q <= rem_q >> GRP_W;
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // R6
   enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
   // R5
   enc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid && !in_ready);
   // R5
   enc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> in_ready);
endmodule

// File: rtl/vlq_dec.sv
module vlq_dec #(
   parameter int unsigned VAL_W = 16,
   parameter int unsigned GRP_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [GRP_W:0]     in_data,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [VAL_W-1:0]   out_value,
   output logic               out_err
);
   import vlq_pkg::*;
   localparam int unsigned NBYTES = grp_count(VAL_W, GRP_W);
   localparam int unsigned IDX_W  = $clog2(NBYTES);
   localparam int unsigned LAST_W = VAL_W - GRP_W * (NBYTES - 1);
   localparam int unsigned WIDE_W = NBYTES * GRP_W;
   localparam logic [GRP_W-1:0] LAST_MASK = GRP_W'((1 << LAST_W) - 1);

   if (GRP_W < 1 || VAL_W <= GRP_W) begin : g_bad_cfg
      $error("vlq_dec: VAL_W must exceed GRP_W >= 1");
   end

   logic [VAL_W-1:0]  acc_q;
   logic [IDX_W-1:0]  idx_q;
   logic              final_byte;
   logic              bad_top;
   logic [GRP_W-1:0]  payload;
   logic [WIDE_W-1:0] merged;

   assign final_byte = (idx_q == IDX_W'(NBYTES - 1));

   // Bits above the final group must be clear in the last byte
   if (LAST_W < GRP_W) begin : g_narrow_last
      assign bad_top = |in_data[GRP_W:LAST_W];
   end else begin : g_full_last
      assign bad_top = in_data[GRP_W];
   end

   always_comb begin
      payload = final_byte ? (in_data[GRP_W-1:0] & LAST_MASK) : in_data[GRP_W-1:0];
      merged  = WIDE_W'(acc_q) | (WIDE_W'(payload) << (int'(idx_q) * GRP_W));
   end

   assign in_ready = ~out_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q     <= '0;
         idx_q     <= '0;
         out_valid <= 1'b0;
         out_value <= '0;
         out_err   <= 1'b0;
      end else if (out_valid) begin
         if (out_ready) out_valid <= 1'b0;
      end else if (in_valid) begin
         if (final_byte || !in_data[GRP_W]) begin
            out_valid <= 1'b1;
            out_value <= merged[VAL_W-1:0];
            out_err   <= final_byte && bad_top;
            acc_q     <= '0;
            idx_q     <= '0;
         end else begin
            acc_q <= merged[VAL_W-1:0];
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // R10
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_err) && !in_ready);
   // R7
   dec_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !in_data[GRP_W] |=> out_valid);
   // R9
   dec_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> in_ready);
endmodule

// File: rtl/vlq_codec.sv
module vlq_codec #(
   parameter int unsigned VAL_W = 16,
   parameter int unsigned GRP_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enc_in_valid,
   output logic             enc_in_ready,
   input  logic [VAL_W-1:0] enc_in_value,
   output logic             enc_byte_valid,
   input  logic             enc_byte_ready,
   output logic [GRP_W:0]   enc_byte_data,
   output logic             enc_byte_last,
   input  logic             dec_byte_valid,
   output logic             dec_byte_ready,
   input  logic [GRP_W:0]   dec_byte_data,
   output logic             dec_out_valid,
   input  logic             dec_out_ready,
   output logic [VAL_W-1:0] dec_out_value,
   output logic             dec_out_err
);
   vlq_enc #(.VAL_W(VAL_W), .GRP_W(GRP_W)) u_enc (
      .clk(clk), .rst_n(rst_n),
      .in_valid(enc_in_valid), .in_ready(enc_in_ready), .in_value(enc_in_value),
      .out_valid(enc_byte_valid), .out_ready(enc_byte_ready),
      .out_data(enc_byte_data), .out_last(enc_byte_last)
   );

   vlq_dec #(.VAL_W(VAL_W), .GRP_W(GRP_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .in_valid(dec_byte_valid), .in_ready(dec_byte_ready), .in_data(dec_byte_data),
      .out_valid(dec_out_valid), .out_ready(dec_out_ready),
      .out_value(dec_out_value), .out_err(dec_out_err)
   );

   // R11
   rst_idle_chk: assert property (@(posedge clk)
      $past(!rst_n) && !rst_n |=> !enc_byte_valid && !dec_out_valid);
endmodule

// File: tb/test_vlq_codec.sv
`timescale 1ns/1ps
module test_vlq_codec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enc_in_valid = 1'b0;
   logic        enc_in_ready;
   logic [15:0] enc_in_value = '0;
   logic        enc_byte_valid;
   logic        enc_byte_ready = 1'b0;
   logic [7:0]  enc_byte_data;
   logic        enc_byte_last;
   logic        dec_byte_valid = 1'b0;
   logic        dec_byte_ready;
   logic [7:0]  dec_byte_data = '0;
   logic        dec_out_valid;
   logic        dec_out_ready = 1'b0;
   logic [15:0] dec_out_value;
   logic        dec_out_err;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #4 clk = ~clk;

   vlq_codec i_vlq_codec (
      .clk(clk), .rst_n(rst_n),
      .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_value(enc_in_value),
      .enc_byte_valid(enc_byte_valid), .enc_byte_ready(enc_byte_ready),
      .enc_byte_data(enc_byte_data), .enc_byte_last(enc_byte_last),
      .dec_byte_valid(dec_byte_valid), .dec_byte_ready(dec_byte_ready), .dec_byte_data(dec_byte_data),
      .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
      .dec_out_value(dec_out_value), .dec_out_err(dec_out_err)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000) begin
         fails  = fails + 1;
         checks = checks + 1;
         $display("FAIL watchdog: act %0d cycles exp < 50000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
      end
   endtask

   // Expected encoding, built from R1..R3
   task automatic expect_bytes(input logic [15:0] v, output logic [7:0] b[3], output int n);
      n = (v < 16'h0080) ? 1 : (v < 16'h4000) ? 2 : 3;
      b[0] = {n > 1, v[6:0]};
      b[1] = {n > 2, v[13:7]};
      b[2] = {6'b0, v[15:14]};
   endtask

   task automatic enc_case(input logic [15:0] v, input int stall);
      logic [7:0] eb[3];
      int n;
      expect_bytes(v, eb, n);
      enc_in_value = v;
      enc_in_valid = 1'b1;
      chk(enc_in_ready == 1'b1, "R5 ready before value", int'(enc_in_ready), 1);
      @(negedge clk);
      enc_in_valid = 1'b0;
      for (int k = 0; k < n; k++) begin
         for (int s = 0; s < stall; s++) begin
            chk(enc_byte_valid && enc_byte_data == eb[k], "R6 byte held", int'(enc_byte_data), int'(eb[k]));
            chk(enc_in_ready == 1'b0, "R5 ready low while busy", int'(enc_in_ready), 0);
            @(negedge clk);
         end
         chk(enc_byte_valid == 1'b1, "R1 byte valid", int'(enc_byte_valid), 1);
         if (k == 0)      chk(enc_byte_data == eb[k], "R1 first byte", int'(enc_byte_data), int'(eb[k]));
         else if (k == 1) chk(enc_byte_data == eb[k], "R2 second byte", int'(enc_byte_data), int'(eb[k]));
         else             chk(enc_byte_data == eb[k], "R3 third byte", int'(enc_byte_data), int'(eb[k]));
         chk(enc_byte_last == (k == n - 1), "R4 last marker", int'(enc_byte_last), int'(k == n - 1));
         chk(enc_in_ready == 1'b0, "R5 ready low until last taken", int'(enc_in_ready), 0);
         enc_byte_ready = 1'b1;
         @(negedge clk);
         enc_byte_ready = 1'b0;
      end
      chk(enc_in_ready == 1'b1, "R5 ready back after last", int'(enc_in_ready), 1);
      chk(enc_byte_valid == 1'b0, "R3 no extra byte", int'(enc_byte_valid), 0);
   endtask

   task automatic dec_case(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                           input int n, input logic [15:0] expv, input bit experr, input int hold);
      logic [7:0] fb[3];
      fb[0] = b0; fb[1] = b1; fb[2] = b2;
      for (int k = 0; k < n; k++) begin
         dec_byte_data  = fb[k];
         dec_byte_valid = 1'b1;
         chk(dec_byte_ready == 1'b1 && dec_out_valid == 1'b0, "R9 ready for byte", int'(dec_byte_ready), 1);
         @(negedge clk);
      end
      dec_byte_valid = 1'b0;
      chk(dec_out_valid == 1'b1, "R7 value due", int'(dec_out_valid), 1);
      chk(dec_out_err == experr, "R8 error flag", int'(dec_out_err), int'(experr));
      if (!experr) chk(dec_out_value == expv, "R7 decoded value", int'(dec_out_value), int'(expv));
      for (int h = 0; h < hold; h++) begin
         dec_byte_valid = 1'b1;
         dec_byte_data  = 8'h7E;
         chk(dec_byte_ready == 1'b0, "R10 input blocked", int'(dec_byte_ready), 0);
         @(negedge clk);
         chk(dec_out_valid && dec_out_err == experr, "R10 output held", int'(dec_out_valid), 1);
         if (!experr) chk(dec_out_value == expv, "R10 value held", int'(dec_out_value), int'(expv));
      end
      dec_byte_valid = 1'b0;
      dec_out_ready  = 1'b1;
      @(negedge clk);
      dec_out_ready  = 1'b0;
      chk(dec_out_valid == 1'b0 && dec_byte_ready == 1'b1, "R9 back to first byte", int'(dec_byte_ready), 1);
   endtask

   task automatic reset_case();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(enc_byte_valid == 1'b0, "R11 enc idle", int'(enc_byte_valid), 0);
      chk(enc_in_ready == 1'b1, "R11 enc ready", int'(enc_in_ready), 1);
      chk(dec_out_valid == 1'b0, "R11 dec idle", int'(dec_out_valid), 0);
      chk(dec_byte_ready == 1'b1, "R11 dec ready", int'(dec_byte_ready), 1);
   endtask

   initial begin
      @(negedge clk);
      reset_case();
      enc_case(16'h0000, 0);
      enc_case(16'h007F, 1);
      enc_case(16'h0080, 0);
      enc_case(16'h3FFF, 2);
      enc_case(16'h4000, 0);
      enc_case(16'hC000, 1);
      enc_case(16'hFFFF, 3);
      enc_case(16'h1234, 0);
      dec_case(8'h00, 8'h00, 8'h00, 1, 16'h0000, 1'b0, 0);
      dec_case(8'h7F, 8'h00, 8'h00, 1, 16'h007F, 1'b0, 2);
      dec_case(8'h80, 8'h01, 8'h00, 2, 16'h0080, 1'b0, 0);
      dec_case(8'hFF, 8'h7F, 8'h00, 2, 16'h3FFF, 1'b0, 1);
      dec_case(8'h80, 8'h80, 8'h03, 3, 16'hC000, 1'b0, 0);
      dec_case(8'hFF, 8'hFF, 8'h03, 3, 16'hFFFF, 1'b0, 3);
      // R8: bit 2 set in final byte, then bit 7 set
      dec_case(8'h80, 8'h80, 8'h04, 3, 16'h0000, 1'b1, 1);
      dec_case(8'h05, 8'h00, 8'h00, 1, 16'h0005, 1'b0, 0);
      dec_case(8'hFF, 8'hFF, 8'h83, 3, 16'h0000, 1'b1, 0);
      dec_case(8'hB4, 8'h24, 8'h00, 2, 16'h1234, 1'b0, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule